// File: doc/BRIEF.md
# MFM Bit-Pair Encoder

This block turns a serial data stream into the bit pairs written to a magnetic medium under Modified Frequency Modulation. Every data bit is held on `data_in` for two clock cycles, and over those two cycles the block emits the two recorded bits, one per cycle, on `disk_out`. A data 1 is always recorded as a pulse in the second half of its cell. A data 0 gets a pulse in the first half only when the data bit before it was also 0. This rule keeps the recorded ones neither adjacent nor too far apart.

The block has no framing input. It keeps its own idea of whether the next sample is the first or the second half of a bit. Data can only change at a bit boundary, so a value that changes between what the block takes to be the two halves of one bit shows that its framing is off by one cycle. The block then treats that sample as the first half of a new bit and carries on from there, so it locks onto the correct phase from any starting point. The output is registered, so the recorded stream comes from a flop and cannot glitch.

Top module: `mfm_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `disk_out` becomes 0. The first sample after reset is taken as the first half of a bit whose previous data bit counts as 1, so a leading 0 records as 00.
- R2: A data bit of 1 records as 0 in the first half-cell, then 1 in the second half-cell.
- R3: A data bit of 0 that follows a data 1 records as 0 then 0.
- R4: A data bit of 0 that follows a data 0 records as 1 then 0.
- R5: The recorded bit for the `data_in` value sampled at a rising edge appears on `disk_out` just after that same edge and holds for the whole cycle (one register of delay).
- R6: Suppose a sample taken as a second half-cell differs from the first-half value of that bit. That cycle then records 0 and is taken as the first half of a new bit whose previous bit is the earlier value. Later bits then encode in correct framing.
- R7: `disk_out` never carries 1 in two consecutive cycles. On a correctly framed stream, any two ones are separated by at least one and at most three zeros.
- R8: With the block freshly reset, the data sequence 1,0,1,0,0,1,1,1,0,0,0,1 records as the 24-bit stream 010001001001010100101001, first bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | Serial data, each bit held for two clock cycles |
| disk_out | output | 1 | Registered recorded bit stream, one half-cell per cycle |

## Verification
Each recorded bit is due exactly one register later: the value on `disk_out` just after a rising edge belongs to the `data_in` half-cell sampled at that edge. The bench therefore changes `data_in` a moment after an edge and compares `disk_out` a moment after the following edge. For R5 it compares again at the falling edge to confirm the value holds. Resynchronisation is checked by inserting a stray half-cell after reset. The stream is then compared against the reference encoder from the first bit that differs from its predecessor, because that difference is the first point at which framing can be recovered.

// File: rtl/mfm_enc_pkg.sv
package mfm_enc_pkg;

    // Phase of the next sample combined with the bit history it needs.
    typedef enum logic [1:0] {
        PH_LEAD_PREV1 = 2'd0,  // next sample is a first half-cell, last bit was 1
        PH_LEAD_PREV0 = 2'd1,  // next sample is a first half-cell, last bit was 0
        PH_TAIL_ONE   = 2'd2,  // next sample is a second half-cell of a 1
        PH_TAIL_ZERO  = 2'd3   // next sample is a second half-cell of a 0
    } mfm_phase_e;

    typedef struct packed {
        mfm_phase_e phase;
        logic       code;
    } mfm_step_t;

endpackage

// File: rtl/mfm_phase_fsm.sv
module mfm_phase_fsm
    import mfm_enc_pkg::*;
#(
    parameter bit RESET_PREV_ONE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_in,
    output mfm_phase_e phase_q,
    output logic       code_bit
);

    localparam mfm_phase_e RESET_PHASE = RESET_PREV_ONE ? PH_LEAD_PREV1 : PH_LEAD_PREV0;

    mfm_step_t step_d;
    mfm_phase_e phase_r_q;

    always_comb begin
        step_d.phase = phase_r_q;
        step_d.code  = 1'b0;
        case (phase_r_q)
            PH_LEAD_PREV1: begin
                step_d.code  = 1'b0;
                step_d.phase = data_in ? PH_TAIL_ONE : PH_TAIL_ZERO;
            end
            PH_LEAD_PREV0: begin
                step_d.code  = ~data_in;
                step_d.phase = data_in ? PH_TAIL_ONE : PH_TAIL_ZERO;
            end
            PH_TAIL_ONE: begin
                if (data_in) begin
                    step_d.code  = 1'b1;
                    step_d.phase = PH_LEAD_PREV1;
                end else begin
                    // framing slip: this is the lead half of a 0 after a 1
                    step_d.code  = 1'b0;
                    step_d.phase = PH_TAIL_ZERO;
                end
            end
            default: begin
                if (!data_in) begin
                    step_d.code  = 1'b0;
                    step_d.phase = PH_LEAD_PREV0;
                end else begin
                    // framing slip: this is the lead half of a 1
                    step_d.code  = 1'b0;
                    step_d.phase = PH_TAIL_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_r_q <= RESET_PHASE;
        end else begin
            phase_r_q <= step_d.phase;
        end
    end

    assign phase_q  = phase_r_q;
    assign code_bit = step_d.code;

    // R6: a tail sample that contradicts its lead lands in the tail of the new value
    a_r6_slip_target: assert property (@(posedge clk) disable iff (rst)
        ((phase_r_q == PH_TAIL_ONE) && !data_in) |=> (phase_r_q == PH_TAIL_ZERO));
    a_r6_slip_target_b: assert property (@(posedge clk) disable iff (rst)
        ((phase_r_q == PH_TAIL_ZERO) && data_in) |=> (phase_r_q == PH_TAIL_ONE));

endmodule

// File: rtl/mfm_disk_reg.sv
module mfm_disk_reg (
    input  logic clk,
    input  logic rst,
    input  logic code_bit,
    output logic disk_q
);

    logic disk_d;

    always_comb begin
        disk_d = code_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disk_q <= 1'b0;
        end else begin
            disk_q <= disk_d;
        end
    end

endmodule

// File: rtl/mfm_encoder.sv
module mfm_encoder
    import mfm_enc_pkg::*;
#(
    parameter bit RESET_PREV_ONE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    output logic disk_out
);

    mfm_phase_e phase_w;
    logic       code_w;

    mfm_phase_fsm #(
        .RESET_PREV_ONE(RESET_PREV_ONE)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .phase_q (phase_w),
        .code_bit(code_w)
    );

    mfm_disk_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .code_bit(code_w),
        .disk_q  (disk_out)
    );

    // R1: leaving reset, output is low and the first sample is a lead half after a 1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!disk_out && (phase_w == PH_LEAD_PREV1 || !RESET_PREV_ONE)));

    // R2: lead half of a 1 records 0, matching tail of a 1 records 1
    a_r2_one_lead: assert property (@(posedge clk) disable iff (rst)
        (((phase_w == PH_LEAD_PREV1) || (phase_w == PH_LEAD_PREV0)) && data_in) |=> !disk_out);
    a_r2_one_tail: assert property (@(posedge clk) disable iff (rst)
        ((phase_w == PH_TAIL_ONE) && data_in) |=> disk_out);

    // R3: a 0 after a 1 records nothing in its lead half
    a_r3_zero_after_one: assert property (@(posedge clk) disable iff (rst)
        ((phase_w == PH_LEAD_PREV1) && !data_in) |=> !disk_out);

    // R4: a 0 after a 0 records a pulse in its lead half
    a_r4_zero_after_zero: assert property (@(posedge clk) disable iff (rst)
        ((phase_w == PH_LEAD_PREV0) && !data_in) |=> disk_out);

    // R6: a contradicting tail sample records 0
    a_r6_slip_quiet: assert property (@(posedge clk) disable iff (rst)
        (((phase_w == PH_TAIL_ONE) && !data_in) || ((phase_w == PH_TAIL_ZERO) && data_in))
        |=> !disk_out);

    // R7: no two adjacent recorded ones
    a_r7_no_adjacent_ones: assert property (@(posedge clk) disable iff (rst)
        disk_out |=> !disk_out);

endmodule

// File: tb/mfm_encoder_tb.sv
module mfm_encoder_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_in = 1'b0;
    logic disk_out;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic prev_bit;
    int zero_run;
    bit seen_one;
    logic [23:0] r8_seen;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mfm_encoder u_dut (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .disk_out(disk_out)
    );

    // reference pair: [1] first half-cell, [0] second half-cell
    function automatic logic [1:0] ref_pair(input logic prev, input logic b);
        return {(~b) & (~prev), b};
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: disk_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one half-cell shortly after an edge, compare after the next edge
    task automatic half(input logic d, input logic exp, input bit chk, input string tag,
                        input bit hold_chk);
        data_in = d;
        @(posedge clk);
        #1;
        if (chk) check(tag, disk_out, exp);
        if (chk) begin
            if (disk_out) begin
                if (seen_one) begin
                    n_checks++;
                    if (zero_run < 1 || zero_run > 3) begin
                        n_bad++;
                        $display("FAIL R7: zero run=%0d expected 1..3", zero_run);
                    end
                end
                seen_one = 1'b1;
                zero_run = 0;
            end else begin
                zero_run++;
            end
        end
        if (hold_chk) begin
            @(negedge clk);
            check("R5 hold", disk_out, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit chk, input bit hold_chk);
        logic [1:0] p;
        string tag;
        p = ref_pair(prev_bit, b);
        tag = b ? "R2" : (prev_bit ? "R3" : "R4");
        half(b, p[1], chk, tag, hold_chk);
        half(b, p[0], chk, tag, hold_chk);
        prev_bit = b;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        data_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1 reset", disk_out, 1'b0);
        rst = 1'b0;
        prev_bit = 1'b1;
        seen_one = 1'b0;
        zero_run = 0;
    endtask

    initial begin
        logic [11:0] r8_bits;
        logic g;
        void'($urandom(32'd20240607));
        repeat (2) @(posedge clk);
        #1;

        // R1: reset state, then a leading 0 records as 00
        do_reset();
        send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b1);

        // R8: fixed sequence
        do_reset();
        r8_bits = 12'b101001110001;
        r8_seen = '0;
        for (int i = 11; i >= 0; i--) begin
            half(r8_bits[i], 1'b0, 1'b0, "R8", 1'b0);
            r8_seen = {r8_seen[22:0], disk_out};
            half(r8_bits[i], 1'b0, 1'b0, "R8", 1'b0);
            r8_seen = {r8_seen[22:0], disk_out};
        end
        n_checks++;
        if (r8_seen !== 24'b010001001001010100101001) begin
            n_bad++;
            $display("FAIL R8: stream=%b expected %b", r8_seen, 24'b010001001001010100101001);
        end

        // R6: stray half-cells after reset, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            do_reset();
            g = pol[0];
            half(g, 1'b0, 1'b0, "R6", 1'b0);
            half(g, 1'b0, 1'b0, "R6", 1'b0);
            half(g, 1'b0, 1'b0, "R6", 1'b0);
            prev_bit = g;
            seen_one = 1'b0;
            zero_run = 0;
            send_bit(~g, 1'b1, 1'b0);
            for (int k = 0; k < 20; k++) send_bit(1'(k % 3 == 0), 1'b1, 1'b0);
        end

        // R2/R3/R4/R7: random streams with mixed run lengths
        for (int burst = 0; burst < 40; burst++) begin
            do_reset();
            for (int k = 0; k < 150; k++) begin
                logic b;
                b = (($urandom % 4) == 0) ? ~prev_bit : prev_bit;
                if (burst % 2 == 1) b = 1'($urandom);
                send_bit(b, 1'b1, (k % 37) == 0);
            end
        end

        // R6 mid-stream: a slip inserted into a running stream
        do_reset();
        for (int k = 0; k < 8; k++) send_bit(1'b1, 1'b1, 1'b0);
        half(1'b1, 1'b0, 1'b0, "R6", 1'b0);
        prev_bit = 1'b1;
        seen_one = 1'b0;
        zero_run = 0;
        send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule